// File: doc/BRIEF.md
# Runtime-Mapped FFT Channel Selector

The block takes FFT spectra presented as P parallel complex channels per clock, one spectrum spread over S consecutive clocks, and emits a narrower stream of Q complex channels per clock over S clocks. Each of the Q·S output slots carries one input channel, chosen through a selection table that can be written and read back while the block runs. One input channel may appear in any number of slots.

Each spectrum is captured whole into one bank of a two-bank store. The bank switches at every sync, so one spectrum is written while the previous one is read out through the table. The table is copied into an active image when the last input cycle of a spectrum ends. Software writes therefore never tear a spectrum that is already being emitted. Output begins a fixed S+1 cycles after the input sync, and the output sync pulse marks that point.

Top module: `chan_selector`

## Requirements
- R1: After reset, sync_o and dout_o are 0 and table slot i holds channel i; readback of slot 0 reads 0.
- R2: Input channel number is (cycle within spectrum)·P + lane. Lane 0 occupies the most significant word of din_i, and each word is {real, imag} of COMP_W bits each.
- R3: Output slot number is group·Q + lane, with lane 0 in the most significant word of dout_o; each slot carries the captured word of the channel the active table holds for that slot.
- R4: sync_o is high for exactly one cycle, S+1 cycles after the cycle in which sync_i is high; output group g appears S+2+g cycles after sync_i.
- R5: dout_o is all zeros in every cycle outside the S-cycle output window of a spectrum.
- R6: Several slots may name the same input channel, and each of them carries that channel's word.
- R7: A write (map_we_i high) stores map_src_i at slot map_slot_i; map_rd_o shows the entry of the slot addressed in the previous cycle, so a slot written in cycle c and addressed in c+1 reads the new value in c+2.
- R8: When a slot is written and addressed in the same cycle, the readback in the next cycle shows the entry it held before the write.
- R9: Spectra may follow each other with a sync period as short as S, the next sync_i coinciding with the previous spectrum's last data cycle; every spectrum is still emitted complete and correct.
- R10: The active table is captured at the clock edge ending a spectrum's last data cycle: writes made in earlier cycles apply to that spectrum; writes made in that cycle or later apply only to later spectra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | One-cycle pulse in the cycle before a spectrum's first data cycle |
| din_i | input | P·2·COMP_W | P complex input channels, lane 0 in the MSBs |
| map_we_i | input | 1 | Table write strobe |
| map_slot_i | input | log2(Q·S) | Table slot to write or read back |
| map_src_i | input | log2(P·S) | Input channel to store in the addressed slot |
| map_rd_o | output | log2(P·S) | Table entry of the slot addressed in the previous cycle |
| sync_o | output | 1 | One-cycle pulse in the cycle before the first output group |
| dout_o | output | Q·2·COMP_W | Q selected complex channels, lane 0 in the MSBs |

## Verification
The bench targets bank hand-off when a spectrum's last data cycle shares its clock with the next sync. A design that flipped banks late or read the wrong bank would emit words tagged with a neighbouring spectrum's number. Table writes are placed in every data cycle while the previous spectrum is still being emitted, including the final cycle. A block that read the live table, or took its snapshot one edge off, would emit a slot with a channel number the model has not yet committed. The table is also loaded with duplicate entries and a reversed order, and it is checked for same-cycle write/read collisions, where a write-first readback would show up at once. Zeros are required on dout_o outside each window, which exposes an output register that is not gated.

// File: rtl/chan_sel_pkg.sv
package chan_sel_pkg;
  localparam int unsigned CS_IN_LANES_LOG2  = 2;
  localparam int unsigned CS_SPAN_LOG2      = 3;
  localparam int unsigned CS_OUT_LANES_LOG2 = 1;
  localparam int unsigned CS_COMP_W         = 4;
endpackage

// File: rtl/chsel_capture.sv
module chsel_capture #(
  parameter int unsigned LANE_W = 2,
  parameter int unsigned SPAN_W = 3,
  parameter int unsigned RD_N   = 2,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned P    = 1 << LANE_W,
  localparam int unsigned CH_W = LANE_W + SPAN_W,
  localparam int unsigned N    = 1 << CH_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic [P*WORD_W-1:0] din_i,
  input  logic                rd_bank_i,
  input  logic [CH_W-1:0]     rd_src_i  [RD_N],
  output logic [WORD_W-1:0]   rd_word_o [RD_N],
  output logic                done_o,
  output logic                bank_o,
  output logic                busy_o
);
  localparam logic [SPAN_W-1:0] LAST = '1;

  logic              busy_q;
  logic [SPAN_W-1:0] cnt_q;
  logic              bank_q;
  logic [WORD_W-1:0] mem_q [2][N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else if (sync_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      bank_q <= ~bank_q;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  // last data cycle may share its edge with the next sync: write uses the old bank
  always_ff @(posedge clk_i) begin
    if (busy_q) begin
      for (int l = 0; l < P; l++) begin
        mem_q[bank_q][{cnt_q, LANE_W'(l)}] <= din_i[(P-1-l)*WORD_W +: WORD_W];
      end
    end
  end

  for (genvar q = 0; q < RD_N; q++) begin : g_rd
    assign rd_word_o[q] = mem_q[rd_bank_i][rd_src_i[q]];
  end

  assign done_o = busy_q && (cnt_q == LAST);
  assign bank_o = bank_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/chsel_map.sv
module chsel_map #(
  parameter int unsigned CH_W     = 5,
  parameter int unsigned SPAN_W   = 3,
  parameter int unsigned OLANE_W  = 1,
  localparam int unsigned Q      = 1 << OLANE_W,
  localparam int unsigned SLOT_W = SPAN_W + OLANE_W,
  localparam int unsigned M      = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CH_W-1:0]   src_i,
  input  logic              load_i,
  input  logic [SPAN_W-1:0] grp_i,
  output logic [CH_W-1:0]   rd_o,
  output logic [CH_W-1:0]   src_o [Q]
);
  logic [CH_W-1:0] tbl_q [M];
  logic [CH_W-1:0] act_q [M];
  logic [CH_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < M; i++) begin
        tbl_q[i] <= CH_W'(i);
        act_q[i] <= CH_W'(i);
      end
      rd_q <= '0;
    end else begin
      rd_q <= tbl_q[slot_i];
      if (we_i) tbl_q[slot_i] <= src_i;
      // snapshot excludes a write landing on the same edge
      if (load_i) begin
        for (int i = 0; i < M; i++) act_q[i] <= tbl_q[i];
      end
    end
  end

  for (genvar q = 0; q < Q; q++) begin : g_src
    assign src_o[q] = act_q[{grp_i, OLANE_W'(q)}];
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/chsel_emit.sv
module chsel_emit #(
  parameter int unsigned SPAN_W  = 3,
  parameter int unsigned Q       = 2,
  parameter int unsigned WORD_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic                bank_i,
  input  logic [WORD_W-1:0]   word_i [Q],
  output logic                rd_bank_o,
  output logic [SPAN_W-1:0]   grp_o,
  output logic                busy_o,
  output logic                sync_o,
  output logic [Q*WORD_W-1:0] dout_o
);
  localparam logic [SPAN_W-1:0] LAST = '1;

  logic                busy_q;
  logic [SPAN_W-1:0]   grp_q;
  logic                bank_q;
  logic                sync_q;
  logic [Q*WORD_W-1:0] dout_q;
  logic [Q*WORD_W-1:0] packed_w;

  always_comb begin
    packed_w = '0;
    for (int q = 0; q < Q; q++) packed_w[(Q-1-q)*WORD_W +: WORD_W] = word_i[q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      grp_q  <= '0;
      bank_q <= 1'b0;
      sync_q <= 1'b0;
      dout_q <= '0;
    end else begin
      sync_q <= done_i;
      dout_q <= busy_q ? packed_w : '0;
      if (done_i) begin
        busy_q <= 1'b1;
        grp_q  <= '0;
        bank_q <= bank_i;
      end else if (busy_q) begin
        grp_q <= grp_q + 1'b1;
        if (grp_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  assign rd_bank_o = bank_q;
  assign grp_o     = grp_q;
  assign busy_o    = busy_q;
  assign sync_o    = sync_q;
  assign dout_o    = dout_q;
endmodule

// File: rtl/chan_selector.sv
module chan_selector
  import chan_sel_pkg::*;
#(
  parameter int unsigned IN_LANES_LOG2  = CS_IN_LANES_LOG2,
  parameter int unsigned SPAN_LOG2      = CS_SPAN_LOG2,
  parameter int unsigned OUT_LANES_LOG2 = CS_OUT_LANES_LOG2,
  parameter int unsigned COMP_W         = CS_COMP_W,
  localparam int unsigned P      = 1 << IN_LANES_LOG2,
  localparam int unsigned Q      = 1 << OUT_LANES_LOG2,
  localparam int unsigned WORD_W = 2 * COMP_W,
  localparam int unsigned CH_W   = IN_LANES_LOG2 + SPAN_LOG2,
  localparam int unsigned SLOT_W = OUT_LANES_LOG2 + SPAN_LOG2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic [P*WORD_W-1:0] din_i,
  input  logic                map_we_i,
  input  logic [SLOT_W-1:0]   map_slot_i,
  input  logic [CH_W-1:0]     map_src_i,
  output logic [CH_W-1:0]     map_rd_o,
  output logic                sync_o,
  output logic [Q*WORD_W-1:0] dout_o
);
  logic                 cap_done;
  logic                 cap_bank;
  logic                 cap_busy;
  logic                 emit_bank;
  logic                 emit_busy;
  logic [SPAN_LOG2-1:0] emit_grp;
  logic [CH_W-1:0]      sel_src  [Q];
  logic [WORD_W-1:0]    sel_word [Q];

  chsel_capture #(
    .LANE_W(IN_LANES_LOG2), .SPAN_W(SPAN_LOG2), .RD_N(Q), .WORD_W(WORD_W)
  ) u_capture (
    .clk_i, .rst_ni, .sync_i, .din_i,
    .rd_bank_i(emit_bank), .rd_src_i(sel_src), .rd_word_o(sel_word),
    .done_o(cap_done), .bank_o(cap_bank), .busy_o(cap_busy)
  );

  chsel_map #(
    .CH_W(CH_W), .SPAN_W(SPAN_LOG2), .OLANE_W(OUT_LANES_LOG2)
  ) u_map (
    .clk_i, .rst_ni, .we_i(map_we_i), .slot_i(map_slot_i), .src_i(map_src_i),
    .load_i(cap_done), .grp_i(emit_grp), .rd_o(map_rd_o), .src_o(sel_src)
  );

  chsel_emit #(
    .SPAN_W(SPAN_LOG2), .Q(Q), .WORD_W(WORD_W)
  ) u_emit (
    .clk_i, .rst_ni, .done_i(cap_done), .bank_i(cap_bank), .word_i(sel_word),
    .rd_bank_o(emit_bank), .grp_o(emit_grp), .busy_o(emit_busy),
    .sync_o, .dout_o
  );
endmodule

// File: rtl/chan_selector_chk.sv
module chan_selector_chk #(
  parameter int unsigned SPAN_LOG2 = 3,
  parameter int unsigned SLOT_W    = 4,
  parameter int unsigned CH_W      = 5,
  parameter int unsigned DOUT_W    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_o,
  input logic [DOUT_W-1:0] dout_o,
  input logic              map_we_i,
  input logic [SLOT_W-1:0] map_slot_i,
  input logic [CH_W-1:0]   map_src_i,
  input logic [CH_W-1:0]   map_rd_o,
  input logic              cap_busy,
  input logic              cap_bank,
  input logic              emit_busy,
  input logic              emit_bank
);
  localparam logic [SPAN_LOG2:0] SPAN = (SPAN_LOG2+1)'(1 << SPAN_LOG2);

  logic [SPAN_LOG2:0] win_q;
  logic [1:0]         age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      age_q <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (sync_o) win_q <= SPAN;
      else if (win_q != '0) win_q <= win_q - 1'b1;
    end
  end

  AST_SYNC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);  // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == '0) |-> (dout_o == '0));  // R5
  AST_BANK_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_busy && emit_busy) |-> (cap_bank != emit_bank));  // R9
  AST_MAP_WRITE_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(map_we_i, 2) && $past(map_slot_i) == $past(map_slot_i, 2))
      |-> (map_rd_o == $past(map_src_i, 2)));  // R7
  AST_MAP_RB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !$past(map_we_i, 2) && $past(map_slot_i) == $past(map_slot_i, 2))
      |-> $stable(map_rd_o));  // R7
endmodule

bind chan_selector chan_selector_chk #(
  .SPAN_LOG2(SPAN_LOG2), .SLOT_W(SLOT_W), .CH_W(CH_W), .DOUT_W(Q*WORD_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_o(sync_o), .dout_o(dout_o),
  .map_we_i(map_we_i), .map_slot_i(map_slot_i), .map_src_i(map_src_i),
  .map_rd_o(map_rd_o), .cap_busy(cap_busy), .cap_bank(cap_bank),
  .emit_busy(emit_busy), .emit_bank(emit_bank)
);

// File: tb/chan_selector_bench.sv
`timescale 1ns/1ps
module chan_selector_bench;
  localparam int P = 4, S = 8, Q = 2, W = 8, N = 32, M = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_i = 1'b0;
  logic [P*W-1:0] din_i = '0;
  logic          map_we_i = 1'b0;
  logic [3:0]    map_slot_i = '0;
  logic [4:0]    map_src_i = '0;
  logic [4:0]    map_rd_o;
  logic          sync_o;
  logic [Q*W-1:0] dout_o;

  int checks = 0, fails = 0, cyc = 0, issued = 0, out_k = 0, cur = 0, pending = 0, grp = 0;
  bit done = 1'b0;
  int sync_cyc [8];
  logic [4:0] snap [8][M];
  logic [4:0] exp_map [M];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  chan_selector #(
    .IN_LANES_LOG2(2), .SPAN_LOG2(3), .OUT_LANES_LOG2(1), .COMP_W(4)
  ) u_chan_selector (
    .clk_i(clk), .rst_ni(rst_n), .sync_i, .din_i, .map_we_i, .map_slot_i,
    .map_src_i, .map_rd_o, .sync_o, .dout_o
  );

  function automatic logic [7:0] gen(int k, int c);
    return 8'(c * 7 + k * 11 + 1);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // output monitor: R2 R3 R4 R5 R6 R9 R10
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pending > 0) begin
        logic [Q*W-1:0] e;
        string tag;
        bit dup;
        dup = 1'b0;
        for (int j = 0; j < Q; j++) begin
          e[(Q-1-j)*W +: W] = gen(cur, int'(snap[cur][grp*Q+j]));
          if (cur == 1 && grp*Q+j >= 8 && grp*Q+j < 12) dup = 1'b1;
        end
        if (cur == 0) tag = "R2";
        else if (cur == 1) tag = dup ? "R6" : "R3";
        else if (cur < 6) tag = "R9";
        else tag = "R10";
        chk(dout_o == e, tag, 64'(dout_o), 64'(e));
        pending--;
        grp++;
      end else begin
        chk(dout_o == '0, "R5", 64'(dout_o), 64'd0);
      end
      if (sync_o) begin
        if (out_k >= issued) begin
          chk(1'b0, "R4", 64'(out_k), 64'(issued));
        end else begin
          chk(cyc == sync_cyc[out_k] + S + 1, "R4", 64'(cyc), 64'(sync_cyc[out_k] + S + 1));
          cur = out_k;
          out_k++;
          pending = S;
          grp = 0;
        end
      end
    end
  end

  task automatic wr_map(int slot, int src);
    map_we_i = 1'b1;
    map_slot_i = 4'(slot);
    map_src_i = 5'(src);
    exp_map[slot] = 5'(src);
    @(negedge clk);
    map_we_i = 1'b0;
  endtask

  task automatic readback_all(string tag);
    for (int i = 0; i < M; i++) begin
      map_slot_i = 4'(i);
      @(negedge clk);
      chk(map_rd_o == exp_map[i], tag, 64'(map_rd_o), 64'(exp_map[i]));
    end
  endtask

  task automatic stream(int k0, int n, int gap, bit wr);
    for (int s = 0; s < n; s++) begin
      int k;
      k = k0 + s;
      if (s == 0 || gap > 0) begin
        sync_i = 1'b1;
        din_i = '0;
        sync_cyc[k] = cyc;
        issued++;
        @(negedge clk);
      end
      for (int t = 0; t < S; t++) begin
        for (int l = 0; l < P; l++) din_i[(P-1-l)*W +: W] = gen(k, t*P + l);
        sync_i = (gap == 0 && s < n - 1 && t == S - 1);
        if (sync_i) begin
          sync_cyc[k+1] = cyc;
          issued++;
        end
        if (t == S - 1) for (int i = 0; i < M; i++) snap[k][i] = exp_map[i];
        map_we_i = 1'b0;
        if (wr && s > 0) begin
          int sl, sr;
          sl = (t*2 + s*3) % M;
          sr = (k*5 + t*3) % N;
          map_we_i = 1'b1;
          map_slot_i = 4'(sl);
          map_src_i = 5'(sr);
          exp_map[sl] = 5'(sr);
        end
        @(negedge clk);
      end
      sync_i = 1'b0;
      map_we_i = 1'b0;
      din_i = '1;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < M; i++) exp_map[i] = 5'(i);
    repeat (3) @(negedge clk);
    chk(sync_o == 1'b0, "R1", 64'(sync_o), 64'd0);
    chk(dout_o == '0, "R1", 64'(dout_o), 64'd0);
    chk(map_rd_o == 5'd0, "R1", 64'(map_rd_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    readback_all("R1");

    stream(0, 1, 0, 1'b0);
    repeat (2*S) @(negedge clk);

    // reversed order plus duplicate sources
    for (int i = 0; i < M; i++) begin
      if (i < 8) wr_map(i, 31 - 3*i);
      else if (i < 12) wr_map(i, 7);
      else wr_map(i, (i*9) % N);
    end
    readback_all("R7");
    stream(1, 1, 0, 1'b0);
    repeat (2*S) @(negedge clk);

    // same-cycle write and read of slot 3
    map_slot_i = 4'd3;
    @(negedge clk);
    map_we_i = 1'b1;
    map_src_i = 5'd19;
    @(negedge clk);
    map_we_i = 1'b0;
    chk(map_rd_o == 5'd22, "R8", 64'(map_rd_o), 64'd22);
    @(negedge clk);
    chk(map_rd_o == 5'd19, "R7", 64'(map_rd_o), 64'd19);
    exp_map[3] = 5'd19;

    stream(2, 4, 0, 1'b1);
    repeat (2*S) @(negedge clk);
    stream(6, 2, 3, 1'b1);
    repeat (2*S + 4) @(negedge clk);
    chk(out_k == issued, "R9", 64'(out_k), 64'(issued));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R4 watchdog: cycles %0d expected below %0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule